// File: doc/BRIEF.md
# Partial-Operand Rewriting Scheduler Window

This block is a small out-of-order scheduler window that holds integer add micro-ops, each with two sources. A source is either known when the op is allocated (its value goes straight into the entry's constant accumulator) or named by a 5-bit producer tag that is still outstanding. Results arrive on a broadcast bus as a tag and a 16-bit value. Ready ops leave through an issue port that carries the destination tag and the final sum.

The window does not wait for both sources of an op. As soon as an entry is down to exactly one outstanding source, it publishes its expression: "my destination equals that remaining tag plus my constant". Any other entry that is waiting on that destination swaps the tag for the remaining tag and adds the published constant to its own. A chain of dependent adds therefore collapses onto one outstanding producer. When that producer's value arrives, every collapsed entry becomes ready at once, without waiting for the intermediate results to be broadcast.

The rewrite is only legal because addition modulo 2^16 is associative and commutative. The block handles adds only.

Top module: `prs_window`

## Requirements
- R1: The window holds DEPTH (default 4) entries. `full_o` is 1 exactly when all of them are occupied. An allocation presented while `full_o` is 1 is dropped and never issues.
- R2: An op allocated with both sources known is ready one edge after allocation. It issues with the sum of the two values.
- R3: A broadcast whose tag equals a pending source of an entry resolves that source and adds the broadcast value to the entry's constant. Each allocated op issues exactly once, with the sum of its two operand values.
- R4: An entry with exactly one pending source publishes its destination, its remaining tag and its constant. At the next edge, an entry waiting on that destination replaces the tag with the remaining tag and adds the published constant. If the remaining tag is on the broadcast bus in that same cycle, the source resolves at once with the broadcast value.
- R5: A dependent add that has absorbed its producer's expression issues the correct sum even if the producer's own result is never broadcast. It becomes ready at the same edge as the producer.
- R6: Absorption uses the published expressions from the previous cycle only, so it crosses one level of dependence per edge. An entry whose source is rewritten onto a tag that has already been consumed waits for that tag's broadcast.
- R7: In a cycle where the broadcast hits any source of an entry, that entry absorbs no published expression. Its other pending source keeps its tag.
- R8: At most one ready entry issues per cycle: the one allocated earliest among the ready entries. An issued entry frees its slot at that edge.
- R9: All sums wrap modulo 2^16.
- R10: After reset the window is empty: `iss_v_o` is 0 and `full_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_v_i | input | 1 | Allocate an add op this cycle |
| alloc_dst_i | input | 5 | Destination tag of the new op |
| alloc_a_tag_i | input | 5 | Producer tag of source A |
| alloc_a_known_i | input | 1 | Source A value is already known |
| alloc_a_val_i | input | 16 | Source A value when known |
| alloc_b_tag_i | input | 5 | Producer tag of source B |
| alloc_b_known_i | input | 1 | Source B value is already known |
| alloc_b_val_i | input | 16 | Source B value when known |
| full_o | output | 1 | All entries are occupied |
| bc_v_i | input | 1 | Result broadcast valid |
| bc_tag_i | input | 5 | Tag of the broadcast result |
| bc_val_i | input | 16 | Value of the broadcast result |
| iss_v_o | output | 1 | An op issues this cycle |
| iss_dst_o | output | 5 | Destination tag of the issuing op |
| iss_val_o | output | 16 | Final sum of the issuing op |

## Verification
The bench aims at the moments when a rewrite and a broadcast land together.

- **Remaining tag broadcast during absorption.** The remaining tag appears on the bus in the very cycle a dependent absorbs. A design that got this wrong would keep a tag that has already gone by, and the op would hang.
- **Producer consumed before the dependent absorbs.** The producer becomes ready one cycle before its dependent can absorb it, and again when the broadcast also hits the dependent's other source. A design that rewrote several levels in one cycle, or that let the rewrite override the bus, would issue the last op early; the bench checks that it stays silent until the intermediate tag is broadcast.

Further cases:
- Age order where the older entry sits in the higher slot, which catches index-priority picking.
- A dropped allocation while full.
- Wrapped sums.
- Random dependence graphs with random arrival skew, whose every issued value is compared with the arithmetic truth.

// File: rtl/prs_pkg.sv
package prs_pkg;
    parameter int unsigned TAG_W  = 5;
    parameter int unsigned DATA_W = 16;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] word_t;

    // One scheduler entry: two sources, each either pending on a tag or folded into acc.
    typedef struct packed {
        logic  live;
        tag_t  dst;
        logic  wait_a;
        tag_t  src_a;
        logic  wait_b;
        tag_t  src_b;
        word_t acc;
    } slot_t;

    // Expression published by an entry that has exactly one pending source.
    typedef struct packed {
        logic  on;
        tag_t  dst;
        tag_t  rest;
        word_t acc;
    } expr_t;
endpackage

// File: rtl/prs_slot.sv
module prs_slot
    import prs_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  slot_t               load_slot_i,
    input  logic                drop_i,
    input  logic                bc_v_i,
    input  tag_t                bc_tag_i,
    input  word_t               bc_val_i,
    input  expr_t [DEPTH-1:0]   pub_i,
    output logic                live_o,
    output logic                ready_o,
    output tag_t                dst_o,
    output word_t               acc_o,
    output expr_t               pub_o
);
    slot_t s_d, s_q;
    logic  hit_a, hit_b;

    always_comb begin
        s_d   = s_q;
        hit_a = s_q.wait_a && bc_v_i && (s_q.src_a == bc_tag_i);
        hit_b = s_q.wait_b && bc_v_i && (s_q.src_b == bc_tag_i);
        if (drop_i) begin
            s_d.live = 1'b0;
        end else if (load_i) begin
            s_d = load_slot_i;
        end else if (s_q.live) begin
            if (hit_a) begin
                s_d.wait_a = 1'b0;
                s_d.acc    = s_d.acc + bc_val_i;
            end
            if (hit_b) begin
                s_d.wait_b = 1'b0;
                s_d.acc    = s_d.acc + bc_val_i;
            end
            // A direct broadcast hit has priority: no absorption this cycle (R7).
            if (!(hit_a || hit_b)) begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (pub_i[j].on) begin
                        if (s_q.wait_a && (s_q.src_a == pub_i[j].dst)) begin
                            s_d.src_a = pub_i[j].rest;
                            s_d.acc   = s_d.acc + pub_i[j].acc;
                            if (bc_v_i && (pub_i[j].rest == bc_tag_i)) begin
                                s_d.wait_a = 1'b0;
                                s_d.acc    = s_d.acc + bc_val_i;
                            end
                        end
                        if (s_q.wait_b && (s_q.src_b == pub_i[j].dst)) begin
                            s_d.src_b = pub_i[j].rest;
                            s_d.acc   = s_d.acc + pub_i[j].acc;
                            if (bc_v_i && (pub_i[j].rest == bc_tag_i)) begin
                                s_d.wait_b = 1'b0;
                                s_d.acc    = s_d.acc + bc_val_i;
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign live_o   = s_q.live;
    assign ready_o  = s_q.live && !s_q.wait_a && !s_q.wait_b;
    assign dst_o    = s_q.dst;
    assign acc_o    = s_q.acc;
    assign pub_o.on   = s_q.live && (s_q.wait_a ^ s_q.wait_b);
    assign pub_o.dst  = s_q.dst;
    assign pub_o.rest = s_q.wait_a ? s_q.src_a : s_q.src_b;
    assign pub_o.acc  = s_q.acc;

    // R3: a resolved entry stays ready until it is issued.
    a_r3_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !drop_i) |=> ready_o);

    // R7: a broadcast hit on source A leaves pending source B's tag untouched.
    a_r7_bc_blocks_rewrite: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.live && !drop_i && !load_i && hit_a && s_q.wait_b && !hit_b)
        |=> (s_q.wait_b && $stable(s_q.src_b)));
endmodule

// File: rtl/prs_age.sv
module prs_age #(
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] load_i,
    input  logic [DEPTH-1:0] ready_i,
    output logic [DEPTH-1:0] grant_o
);
    // older_q[i][j] = 1 when slot i was allocated before slot j.
    logic [DEPTH-1:0][DEPTH-1:0] older_d, older_q;

    always_comb begin
        older_d = older_q;
        for (int s = 0; s < DEPTH; s++) begin
            if (load_i[s]) begin
                for (int j = 0; j < DEPTH; j++) begin
                    older_d[s][j] = 1'b0;
                    older_d[j][s] = (j != s);
                end
            end
        end
    end

    always_comb begin
        grant_o = ready_i;
        for (int i = 0; i < DEPTH; i++) begin
            for (int j = 0; j < DEPTH; j++) begin
                if ((j != i) && ready_i[j] && older_q[j][i]) grant_o[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) older_q <= '0;
        else        older_q <= older_d;
    end

    // R8: one issue per cycle.
    a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_row
        for (genvar gj = 0; gj < DEPTH; gj++) begin : g_col
            if (gi != gj) begin : g_pair
                // R8: the granted entry is older than every other ready entry.
                a_r8_oldest_first: assert property (@(posedge clk) disable iff (!rst_n)
                    (grant_o[gi] && ready_i[gj]) |-> older_q[gi][gj]);
            end
        end
    end
endmodule

// File: rtl/prs_window.sv
module prs_window
    import prs_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_v_i,
    input  logic [prs_pkg::TAG_W-1:0]  alloc_dst_i,
    input  logic [prs_pkg::TAG_W-1:0]  alloc_a_tag_i,
    input  logic                    alloc_a_known_i,
    input  logic [prs_pkg::DATA_W-1:0] alloc_a_val_i,
    input  logic [prs_pkg::TAG_W-1:0]  alloc_b_tag_i,
    input  logic                    alloc_b_known_i,
    input  logic [prs_pkg::DATA_W-1:0] alloc_b_val_i,
    output logic                    full_o,
    input  logic                    bc_v_i,
    input  logic [prs_pkg::TAG_W-1:0]  bc_tag_i,
    input  logic [prs_pkg::DATA_W-1:0] bc_val_i,
    output logic                    iss_v_o,
    output logic [prs_pkg::TAG_W-1:0]  iss_dst_o,
    output logic [prs_pkg::DATA_W-1:0] iss_val_o
);
    logic [DEPTH-1:0]  live, ready, load, grant;
    tag_t              dst   [DEPTH];
    word_t             acc   [DEPTH];
    expr_t [DEPTH-1:0] pubs;
    slot_t             fresh;

    // Lowest free slot takes the new op; nothing is taken when the window is full.
    always_comb begin
        load = '0;
        if (alloc_v_i) begin
            for (int i = DEPTH - 1; i >= 0; i--) begin
                if (!live[i]) load = DEPTH'(1) << i;
            end
        end
    end

    always_comb begin
        fresh.live   = 1'b1;
        fresh.dst    = alloc_dst_i;
        fresh.wait_a = !alloc_a_known_i;
        fresh.src_a  = alloc_a_tag_i;
        fresh.wait_b = !alloc_b_known_i;
        fresh.src_b  = alloc_b_tag_i;
        fresh.acc    = (alloc_a_known_i ? alloc_a_val_i : '0)
                     + (alloc_b_known_i ? alloc_b_val_i : '0);
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        prs_slot #(.DEPTH(DEPTH)) i_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .load_i      (load[gi]),
            .load_slot_i (fresh),
            .drop_i      (grant[gi]),
            .bc_v_i      (bc_v_i),
            .bc_tag_i    (bc_tag_i),
            .bc_val_i    (bc_val_i),
            .pub_i       (pubs),
            .live_o      (live[gi]),
            .ready_o     (ready[gi]),
            .dst_o       (dst[gi]),
            .acc_o       (acc[gi]),
            .pub_o       (pubs[gi])
        );
    end

    prs_age #(.DEPTH(DEPTH)) i_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .ready_i (ready),
        .grant_o (grant)
    );

    always_comb begin
        iss_dst_o = '0;
        iss_val_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (grant[i]) begin
                iss_dst_o = dst[i];
                iss_val_o = acc[i];
            end
        end
    end

    assign iss_v_o = |grant;
    assign full_o  = &live;

    // R1: a dropped allocation while full leaves the window full.
    a_r1_full_blocks_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && alloc_v_i && !iss_v_o) |=> full_o);

    // R2: an op with both sources known is ready right after allocation.
    a_r2_known_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_v_i && !full_o && alloc_a_known_i && alloc_b_known_i) |=> (ready != '0));
endmodule

// File: tb/test_prs_window.sv
module test_prs_window;
    import prs_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int N_ADD      = 12;
    localparam int N_LEAF     = 6;
    localparam int ROUNDS     = 20;

    logic  clk = 1'b0;
    logic  rst_n;
    logic  alloc_v, alloc_ak, alloc_bk, full;
    tag_t  alloc_dst, alloc_at, alloc_bt;
    word_t alloc_av, alloc_bv;
    logic  bc_v;
    tag_t  bc_tag;
    word_t bc_val;
    logic  iss_v;
    tag_t  iss_dst;
    word_t iss_val;

    prs_window #(.DEPTH(DEPTH)) i_prs_window (
        .clk(clk), .rst_n(rst_n),
        .alloc_v_i(alloc_v), .alloc_dst_i(alloc_dst),
        .alloc_a_tag_i(alloc_at), .alloc_a_known_i(alloc_ak), .alloc_a_val_i(alloc_av),
        .alloc_b_tag_i(alloc_bt), .alloc_b_known_i(alloc_bk), .alloc_b_val_i(alloc_bv),
        .full_o(full),
        .bc_v_i(bc_v), .bc_tag_i(bc_tag), .bc_val_i(bc_val),
        .iss_v_o(iss_v), .iss_dst_o(iss_dst), .iss_val_o(iss_val)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    logic  obs_v;
    tag_t  obs_dst;
    word_t obs_val;
    int    seen_cnt [32];

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock edge; samples the issue port just after it, then idles the inputs.
    task automatic tick();
        @(posedge clk);
        #1;
        obs_v   = iss_v;
        obs_dst = iss_dst;
        obs_val = iss_val;
        if (iss_v) seen_cnt[iss_dst]++;
        alloc_v = 1'b0;
        bc_v    = 1'b0;
    endtask

    task automatic put(int dst, int at, bit ak, int av, int bt, bit bk, int bv);
        alloc_v   = 1'b1;
        alloc_dst = tag_t'(dst);
        alloc_at  = tag_t'(at);
        alloc_ak  = ak;
        alloc_av  = word_t'(av);
        alloc_bt  = tag_t'(bt);
        alloc_bk  = bk;
        alloc_bv  = word_t'(bv);
    endtask

    task automatic bcast(int tag, int val);
        bc_v   = 1'b1;
        bc_tag = tag_t'(tag);
        bc_val = word_t'(val);
    endtask

    task automatic expect_issue(string req, int dst, int val);
        checks++;
        if (!(obs_v && obs_dst == tag_t'(dst) && obs_val == word_t'(val))) begin
            fails++;
            $display("FAIL %s: actual v=%0b dst=%0d val=%0d expected v=1 dst=%0d val=%0d",
                     req, obs_v, obs_dst, obs_val, dst, val);
        end
    endtask

    task automatic expect_none(string req);
        chk(!obs_v, req, int'(obs_v), 0);
    endtask

    // Random-phase state
    word_t truth [32];
    bit    sent  [32];
    bit    a_cst [N_ADD];
    bit    b_cst [N_ADD];
    int    a_src [N_ADD];
    int    b_src [N_ADD];
    word_t a_cv  [N_ADD];
    word_t b_cv  [N_ADD];
    int    fbq   [16];

    function automatic word_t rand_word();
        int r;
        r = $urandom % 8;
        if (r == 0) return 16'hFFFF;
        if (r == 1) return 16'h8000;
        return word_t'($urandom);
    endfunction

    function automatic word_t opnd(bit c, int src, word_t cv);
        return c ? cv : truth[src];
    endfunction

    task automatic random_round();
        int nxt, issued, fbh, fbt, unsent, guard, bt;
        bit ak, bk;
        word_t av, bv;
        for (int t = 0; t < 32; t++) begin
            sent[t] = 1'b0;
            seen_cnt[t] = 0;
        end
        for (int l = 0; l < N_LEAF; l++) truth[l] = rand_word();
        for (int i = 0; i < N_ADD; i++) begin
            int r;
            r = $urandom % 10;
            a_cst[i] = (r < 3);
            a_src[i] = (i > 0 && r < 7) ? 8 + int'($urandom % i) : int'($urandom % N_LEAF);
            a_cv[i]  = rand_word();
            r = $urandom % 10;
            b_cst[i] = (r < 3);
            b_src[i] = (i > 0 && r < 7) ? 8 + int'($urandom % i) : int'($urandom % N_LEAF);
            b_cv[i]  = rand_word();
            truth[8 + i] = opnd(a_cst[i], a_src[i], a_cv[i]) + opnd(b_cst[i], b_src[i], b_cv[i]);
        end
        nxt = 0; issued = 0; fbh = 0; fbt = 0; unsent = N_LEAF; guard = 0;
        while (issued < N_ADD && guard < 3000) begin
            guard++;
            bt = -1;
            if ($urandom % 4 != 0) begin
                if (fbh != fbt && (($urandom % 2) == 1 || unsent == 0)) begin
                    bt = fbq[fbh];
                    fbh++;
                end else if (unsent > 0) begin
                    bt = int'($urandom % N_LEAF);
                    while (sent[bt]) bt = (bt + 1) % N_LEAF;
                    unsent--;
                end
            end
            if (bt >= 0) begin
                bcast(bt, int'(truth[bt]));
                sent[bt] = 1'b1;
            end
            if (nxt < N_ADD && !full && ($urandom % 2) == 1) begin
                ak = a_cst[nxt] || sent[a_src[nxt]];
                bk = b_cst[nxt] || sent[b_src[nxt]];
                av = opnd(a_cst[nxt], a_src[nxt], a_cv[nxt]);
                bv = opnd(b_cst[nxt], b_src[nxt], b_cv[nxt]);
                put(8 + nxt, a_src[nxt], ak, int'(av), b_src[nxt], bk, int'(bv));
                nxt++;
            end
            tick();
            if (obs_v) begin
                // R4 R5 R9: every issued value equals the true wrapped sum.
                chk(obs_dst >= 8 && obs_dst < 8 + N_ADD && obs_val == truth[obs_dst],
                    "R4 random issue value", int'(obs_val), int'(truth[obs_dst]));
                fbq[fbt] = int'(obs_dst);
                fbt++;
                issued++;
            end
        end
        for (int i = 0; i < N_ADD; i++) begin
            chk(seen_cnt[8 + i] == 1, "R3 each op issues once", seen_cnt[8 + i], 1);
        end
        repeat (3) tick();
    endtask

    initial begin
        rst_n = 1'b0;
        alloc_v = 1'b0; alloc_dst = '0; alloc_at = '0; alloc_ak = 1'b0; alloc_av = '0;
        alloc_bt = '0; alloc_bk = 1'b0; alloc_bv = '0;
        bc_v = 1'b0; bc_tag = '0; bc_val = '0;
        for (int t = 0; t < 32; t++) seen_cnt[t] = 0;
        $urandom(1234);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        // R10: empty after reset
        expect_none("R10 no issue after reset");
        chk(!full, "R10 not full after reset", int'(full), 0);

        // R2 R9: both known, wrapped sum FFF0+0020 = 0010
        put(1, 0, 1, 'hFFF0, 0, 1, 'h20);
        tick();
        expect_issue("R2 R9 known operands issue next cycle", 1, 'h10);
        tick();
        expect_none("R8 issued entry freed");

        // R3: one pending source resolved by broadcast
        put(2, 20, 0, 0, 0, 1, 5);
        tick();
        expect_none("R3 waits for broadcast");
        bcast(20, 9);
        tick();
        expect_issue("R3 broadcast resolves source", 2, 14);
        tick();

        // R4 R5: P=10:=21+22, D=11:=10+5; 22 arrives early, then 21; tag 10 never broadcast
        put(10, 21, 0, 0, 22, 0, 0);
        tick();
        put(11, 10, 0, 0, 0, 1, 5);
        tick();
        bcast(22, 100);
        tick();
        tick();
        bcast(21, 7);
        tick();
        expect_issue("R8 older producer first", 10, 107);
        tick();
        expect_issue("R5 R4 flattened dependent issues next", 11, 112);
        tick();
        expect_none("R5 nothing left");

        // R7: D=13:=12+23; broadcast of 23 hits D and completes producer 12 in the same cycle
        put(12, 23, 0, 0, 24, 0, 0);
        tick();
        put(13, 12, 0, 0, 23, 0, 0);
        tick();
        bcast(24, 100);
        tick();
        bcast(23, 7);
        tick();
        expect_issue("R7 producer issues", 12, 107);
        tick();
        expect_none("R7 dependent still waits on tag 12");
        bcast(12, 107);
        tick();
        expect_issue("R7 dependent after tag 12 broadcast", 13, 114);
        tick();

        // R6: chain 14 -> 15 -> 16, the last allocated late
        put(14, 25, 0, 0, 26, 0, 0);
        tick();
        put(15, 14, 0, 0, 0, 1, 1);
        tick();
        tick();
        bcast(26, 100);
        put(16, 15, 0, 0, 0, 1, 2);
        tick();
        bcast(25, 7);
        tick();
        expect_issue("R6 chain head", 14, 107);
        tick();
        expect_issue("R6 R4 level one resolved on absorb", 15, 108);
        tick();
        expect_none("R6 second level only one step per cycle");
        bcast(14, 107);
        tick();
        expect_issue("R6 second level after broadcast", 16, 110);
        tick();

        // R8: older entry sits in the higher slot
        put(17, 0, 1, 3, 0, 1, 4);
        tick();
        expect_issue("R2 known op", 17, 7);
        put(18, 28, 0, 0, 0, 1, 1);
        tick();
        put(19, 28, 0, 0, 0, 1, 2);
        tick();
        bcast(28, 10);
        tick();
        expect_issue("R8 oldest ready first", 18, 11);
        tick();
        expect_issue("R8 younger next", 19, 12);
        tick();

        // R1: fill the window, then try one more
        for (int i = 0; i < DEPTH; i++) begin
            put(20 + i, 29, 0, 0, 0, 1, i + 1);
            tick();
        end
        chk(full, "R1 full after DEPTH allocations", int'(full), 1);
        put(24, 0, 1, 1, 0, 1, 1);
        tick();
        expect_none("R1 allocation while full dropped");
        bcast(29, 0);
        tick();
        for (int i = 0; i < DEPTH; i++) begin
            expect_issue("R8 R1 drain in age order", 20 + i, i + 1);
            tick();
        end
        expect_none("R1 dropped op never issues");
        chk(!full, "R1 not full after drain", int'(full), 0);
        chk(seen_cnt[24] == 0, "R1 dropped op count", seen_cnt[24], 0);

        for (int r = 0; r < ROUNDS; r++) random_round();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule